// File: doc/BRIEF.md
# Trap and Interrupt Service Arbiter

This block sits beside the instruction sequencer of a minicomputer-class CPU. At the end of every instruction it looks at everything that might interrupt normal flow and picks the one event to service next: one of three non-trace traps (MMU abort, access to missing memory, yellow-zone stack overflow), a device interrupt, or the trace trap. The selection and the vector to fetch appear as a one-cycle grant. Fetching the vector and pushing the old PC and PSW are left to the sequencer.

Ranking puts every non-trace trap above interrupts, and interrupts above the trace trap. When an interrupt or a higher trap takes the slot that a trace would have used, the trace is held back. It is then granted when a later instruction completes as a return-from-interrupt. A traced WAIT instruction parks the arbiter in a stall state until an interrupt qualifies, and it raises no trace of its own at that point. In kernel mode, a set-priority-level instruction suppresses every grant at its end, so the next instruction always runs. In the other modes it is treated like any other instruction. A combinational prefetch-allowed output tells the decoder whether it may fetch the next instruction early.

The controller has three states. EXEC means an instruction is running. GRANT drives a one-cycle service pulse. STALL means a WAIT is parked. The transitions are:
- EXEC to GRANT: an instruction ends with an event selected.
- EXEC to STALL: a WAIT ends with no trap or interrupt selected.
- EXEC to EXEC: an instruction ends with nothing selected, or a kernel-mode SPL ends.
- STALL to GRANT: an interrupt qualifies.
- GRANT to EXEC: always, on the next edge.

Top module: `trap_irq_arbiter`

## Requirements
- R1: After reset, svc_valid and stalled are 0, svc_sel is 0, and prefetch_ok is 1 when nothing is pending.
- R2: Among the non-trace traps, MMU abort (svc_sel=1, vector 0o250) ranks above missing memory (svc_sel=2, vector 0o4), which ranks above yellow stack (svc_sel=3, vector 0o4).
- R3: Any non-trace trap pending at the end of an instruction is chosen over a qualifying interrupt and over the trace trap.
- R4: An interrupt qualifies only when irq_pri is strictly greater than cpu_pri. When granted, svc_sel=4 and svc_vec equals irq_vec sampled at the deciding edge.
- R5: When a qualifying interrupt and the trace request meet at the end of an instruction, the interrupt is granted and the trace is held back. The trace (svc_sel=5, vector 0o14) is then granted at the end of the first later instruction flagged by last_rti, and not at the end of other instructions before that.
- R6: A trace request with no other event selected (including a non-qualifying interrupt) produces svc_sel=5 with vector 0o14.
- R7: A WAIT that ends with no trap and no qualifying interrupt raises stalled and grants nothing, even when traced. The stall lasts until an interrupt qualifies, which is then granted. A trace from that WAIT is taken at the next last_rti completion.
- R8: At the end of an SPL executed with cur_mode=2'b00 (kernel), nothing is granted whatever is pending, and prefetch_ok is 1.
- R9: At the end of an SPL executed with cur_mode other than 2'b00, events are selected exactly as after any other instruction.
- R10: In EXEC, except for a kernel-mode SPL, prefetch_ok is 0 whenever a non-trace trap, the trace request or a qualifying interrupt is pending.
- R11: A grant is a single-cycle svc_valid pulse in the cycle after the deciding edge. It is followed by a cycle with svc_valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_done | input | 1 | Current instruction completes at this edge |
| last_spl | input | 1 | Completing or decoding instruction is SPL |
| last_wait | input | 1 | Completing instruction is WAIT |
| last_rti | input | 1 | Completing instruction is a return-from-interrupt |
| cur_mode | input | 2 | Processor mode: 00 kernel, 01 supervisor, 11 user |
| cpu_pri | input | 3 | Processor priority field |
| tbit_armed | input | 1 | Trace request armed from T bit at instruction start |
| pend_mmu | input | 1 | MMU abort trap pending |
| pend_nxm | input | 1 | Missing-memory trap pending |
| pend_ysv | input | 1 | Yellow-zone stack trap pending |
| irq_req | input | 1 | Device interrupt request |
| irq_pri | input | 3 | Priority of the interrupt request |
| irq_vec | input | 9 | Vector of the interrupt request |
| svc_valid | output | 1 | One-cycle service grant |
| svc_sel | output | 3 | Selected event: 0 none, 1 MMU, 2 NXM, 3 yellow, 4 interrupt, 5 trace |
| svc_vec | output | 9 | Vector of the selected event |
| prefetch_ok | output | 1 | Decoder may prefetch the next instruction |
| stalled | output | 1 | A WAIT is parked awaiting an interrupt |

## Verification
The assertions assume that instr_done is raised only while the arbiter is in EXEC, never during a grant or a stall. They also assume that last_spl and last_wait are never raised together. The stimulus meets these assumptions: it raises instr_done for exactly one cycle and then waits for the grant cycle to pass before issuing the next completion. It raises the interrupt request during a stall instead of a completion. Each table vector starts from reset, so a held-back trace from one vector cannot leak into the next; the held-back paths are exercised only by the directed sequences.

// File: rtl/arb_pkg.sv
package arb_pkg;
    typedef enum logic [2:0] {
        SEL_NONE = 3'd0,
        SEL_MMU  = 3'd1,
        SEL_NXM  = 3'd2,
        SEL_YSV  = 3'd3,
        SEL_IRQ  = 3'd4,
        SEL_TRC  = 3'd5
    } svc_sel_e;

    typedef enum logic [1:0] {
        ST_EXEC  = 2'd0,
        ST_GRANT = 2'd1,
        ST_STALL = 2'd2
    } arb_state_e;

    localparam int unsigned N_EVENTS    = 5;
    localparam logic [1:0]  MODE_KERNEL = 2'b00;

    // rank order, index 0 highest
    function automatic svc_sel_e rank_code(input int unsigned idx);
        case (idx)
            0:       rank_code = SEL_MMU;
            1:       rank_code = SEL_NXM;
            2:       rank_code = SEL_YSV;
            3:       rank_code = SEL_IRQ;
            default: rank_code = SEL_TRC;
        endcase
    endfunction
endpackage

// File: rtl/arb_irq_qualify.sv
module arb_irq_qualify #(
    parameter int unsigned PRI_W = 3
) (
    input  logic             irq_req,
    input  logic [PRI_W-1:0] irq_pri,
    input  logic [PRI_W-1:0] cpu_pri,
    output logic             irq_ok
);
    always_comb begin
        irq_ok = irq_req && (irq_pri > cpu_pri);
    end
endmodule

// File: rtl/arb_event_pick.sv
module arb_event_pick
    import arb_pkg::*;
(
    input  logic [N_EVENTS-1:0] req,   // index 0 is highest rank
    output svc_sel_e            pick
);
    logic [N_EVENTS-1:0] higher_seen;
    logic [N_EVENTS-1:0] win;

    // higher_seen[i] is set when some event ranked above i is requesting
    assign higher_seen[0] = 1'b0;
    genvar gi;
    generate
        for (gi = 1; gi < N_EVENTS; gi++) begin : g_chain
            assign higher_seen[gi] = higher_seen[gi-1] | req[gi-1];
        end
        for (gi = 0; gi < N_EVENTS; gi++) begin : g_win
            assign win[gi] = req[gi] & ~higher_seen[gi];
        end
    endgenerate

    always_comb begin
        pick = SEL_NONE;
        for (int i = 0; i < N_EVENTS; i++) begin
            if (win[i]) pick = rank_code(i);
        end
    end

    always_comb begin
        assert ($onehot0(win));
    end
endmodule

// File: rtl/arb_vec_select.sv
module arb_vec_select
    import arb_pkg::*;
#(
    parameter int unsigned VEC_W   = 9,
    parameter logic [VEC_W-1:0] VEC_MMU = 9'o250,
    parameter logic [VEC_W-1:0] VEC_NXM = 9'o004,
    parameter logic [VEC_W-1:0] VEC_YSV = 9'o004,
    parameter logic [VEC_W-1:0] VEC_TRC = 9'o014
) (
    input  svc_sel_e         sel,
    input  logic [VEC_W-1:0] irq_vec,
    output logic [VEC_W-1:0] vec
);
    always_comb begin
        unique case (sel)
            SEL_MMU: vec = VEC_MMU;
            SEL_NXM: vec = VEC_NXM;
            SEL_YSV: vec = VEC_YSV;
            SEL_IRQ: vec = irq_vec;
            SEL_TRC: vec = VEC_TRC;
            default: vec = '0;
        endcase
    end
endmodule

// File: rtl/trap_irq_arbiter.sv
module trap_irq_arbiter
    import arb_pkg::*;
#(
    parameter int unsigned PRI_W  = 3,
    parameter int unsigned VEC_W  = 9,
    parameter int unsigned MODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_done,
    input  logic              last_spl,
    input  logic              last_wait,
    input  logic              last_rti,
    input  logic [MODE_W-1:0] cur_mode,
    input  logic [PRI_W-1:0]  cpu_pri,
    input  logic              tbit_armed,
    input  logic              pend_mmu,
    input  logic              pend_nxm,
    input  logic              pend_ysv,
    input  logic              irq_req,
    input  logic [PRI_W-1:0]  irq_pri,
    input  logic [VEC_W-1:0]  irq_vec,
    output logic              svc_valid,
    output logic [2:0]        svc_sel,
    output logic [VEC_W-1:0]  svc_vec,
    output logic              prefetch_ok,
    output logic              stalled
);
    arb_state_e st_q, st_d;
    svc_sel_e   sel_q, pick, pick_eff;
    logic [VEC_W-1:0] vec_q, vec_d;
    logic trc_hold_q, trc_hold_d;
    logic irq_ok, spl_kern, trc_cand, hi_trap;
    logic [N_EVENTS-1:0] req;

    assign spl_kern = last_spl && (cur_mode == MODE_KERNEL[MODE_W-1:0]);
    assign trc_cand = tbit_armed || (trc_hold_q && last_rti);
    assign hi_trap  = pend_mmu || pend_nxm || pend_ysv;

    arb_irq_qualify #(.PRI_W(PRI_W)) u_qual (
        .irq_req (irq_req),
        .irq_pri (irq_pri),
        .cpu_pri (cpu_pri),
        .irq_ok  (irq_ok)
    );

    // in STALL only interrupts wake the arbiter
    always_comb begin
        if (st_q == ST_STALL) req = {1'b0, irq_ok, 3'b000};
        else                  req = {trc_cand, irq_ok, pend_ysv, pend_nxm, pend_mmu};
    end

    arb_event_pick u_pick (
        .req  (req),
        .pick (pick)
    );

    // a traced WAIT does not trap by itself; it parks instead
    assign pick_eff = (last_wait && pick == SEL_TRC) ? SEL_NONE : pick;

    arb_vec_select #(.VEC_W(VEC_W)) u_vec (
        .sel     (pick_eff),
        .irq_vec (irq_vec),
        .vec     (vec_d)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_EXEC;
        else        st_q <= st_d;
    end

    // next state and held-back trace
    always_comb begin
        st_d       = st_q;
        trc_hold_d = trc_hold_q;
        unique case (st_q)
            ST_EXEC: begin
                if (instr_done && !spl_kern) begin
                    if (pick_eff != SEL_NONE) st_d = ST_GRANT;
                    else if (last_wait)       st_d = ST_STALL;
                    if (pick_eff == SEL_TRC)  trc_hold_d = 1'b0;
                    else if (trc_cand)        trc_hold_d = 1'b1;
                end
            end
            ST_GRANT: st_d = ST_EXEC;
            ST_STALL: if (irq_ok) st_d = ST_GRANT;
            default:  st_d = ST_EXEC;
        endcase
    end

    // grant data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q      <= SEL_NONE;
            vec_q      <= '0;
            trc_hold_q <= 1'b0;
        end else begin
            trc_hold_q <= trc_hold_d;
            if (st_d == ST_GRANT) begin
                sel_q <= pick_eff;
                vec_q <= vec_d;
            end else if (st_q == ST_GRANT) begin
                sel_q <= SEL_NONE;
                vec_q <= '0;
            end
        end
    end

    // outputs
    always_comb begin
        svc_valid   = (st_q == ST_GRANT);
        stalled     = (st_q == ST_STALL);
        svc_sel     = sel_q;
        svc_vec     = vec_q;
        prefetch_ok = (st_q == ST_EXEC) &&
                      (spl_kern || !(hi_trap || tbit_armed || irq_ok));
    end

    // R11
    grant_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        svc_valid |=> !svc_valid);
    // R11
    grant_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        svc_valid |-> svc_sel != 3'd0);
    // R8
    spl_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_EXEC && instr_done && spl_kern) |=> !svc_valid);
    // R3
    trap_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_EXEC && instr_done && !spl_kern && hi_trap)
            |=> (svc_valid && svc_sel inside {3'd1, 3'd2, 3'd3}));
    // R5
    irq_over_trc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_EXEC && instr_done && !spl_kern && !hi_trap && irq_ok)
            |=> (svc_sel == 3'd4));
    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_STALL && !irq_ok) |=> (stalled && !svc_valid));
    // R10
    prefetch_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_trap && !spl_kern) |-> !prefetch_ok);
    // R2
    mmu_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_valid && svc_sel == 3'd1) |-> svc_vec == 9'o250);
endmodule

// File: tb/sim_trap_irq_arbiter.sv
module sim_trap_irq_arbiter;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic instr_done = 0, last_spl = 0, last_wait = 0, last_rti = 0;
    logic [1:0] cur_mode = 2'b00;
    logic [2:0] cpu_pri = 3'd0;
    logic tbit_armed = 0, pend_mmu = 0, pend_nxm = 0, pend_ysv = 0, irq_req = 0;
    logic [2:0] irq_pri = 3'd0;
    logic [8:0] irq_vec = 9'd0;
    logic svc_valid, prefetch_ok, stalled;
    logic [2:0] svc_sel;
    logic [8:0] svc_vec;
    int n_run = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    trap_irq_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .instr_done(instr_done), .last_spl(last_spl),
        .last_wait(last_wait), .last_rti(last_rti), .cur_mode(cur_mode),
        .cpu_pri(cpu_pri), .tbit_armed(tbit_armed), .pend_mmu(pend_mmu),
        .pend_nxm(pend_nxm), .pend_ysv(pend_ysv), .irq_req(irq_req),
        .irq_pri(irq_pri), .irq_vec(irq_vec), .svc_valid(svc_valid),
        .svc_sel(svc_sel), .svc_vec(svc_vec), .prefetch_ok(prefetch_ok),
        .stalled(stalled)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_in();
        instr_done = 0; last_spl = 0; last_wait = 0; last_rti = 0;
        cur_mode = 2'b00; cpu_pri = 0; tbit_armed = 0;
        pend_mmu = 0; pend_nxm = 0; pend_ysv = 0;
        irq_req = 0; irq_pri = 0; irq_vec = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        clear_in();
        rst_n = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1;
    endtask

    // one completion: pulse instr_done, sample the cycle after the edge
    task automatic complete();
        instr_done = 1;
        @(posedge clk);
        @(negedge clk);
        clear_in();
    endtask

    // fields: req[29:26] mmu nxm ysv tb irq ipri[3] cpri[3] mode[2] spl sel[3] vec[9]
    localparam int NV = 14;
    localparam logic [29:0] TBL [NV] = '{
        {4'd2, 1'b1,1'b0,1'b0,1'b0,1'b0, 3'd0,3'd0, 2'b00,1'b0, 3'd1, 9'o250}, // R2
        {4'd2, 1'b1,1'b1,1'b1,1'b0,1'b0, 3'd0,3'd0, 2'b00,1'b0, 3'd1, 9'o250}, // R2
        {4'd2, 1'b0,1'b1,1'b1,1'b0,1'b0, 3'd0,3'd0, 2'b00,1'b0, 3'd2, 9'o004}, // R2
        {4'd2, 1'b0,1'b0,1'b1,1'b0,1'b0, 3'd0,3'd0, 2'b00,1'b0, 3'd3, 9'o004}, // R2
        {4'd3, 1'b0,1'b0,1'b1,1'b1,1'b1, 3'd5,3'd0, 2'b00,1'b0, 3'd3, 9'o004}, // R3
        {4'd4, 1'b0,1'b0,1'b0,1'b0,1'b1, 3'd5,3'd4, 2'b00,1'b0, 3'd4, 9'o060}, // R4
        {4'd4, 1'b0,1'b0,1'b0,1'b0,1'b1, 3'd4,3'd4, 2'b00,1'b0, 3'd0, 9'o070}, // R4
        {4'd5, 1'b0,1'b0,1'b0,1'b1,1'b1, 3'd7,3'd6, 2'b00,1'b0, 3'd4, 9'o100}, // R5
        {4'd6, 1'b0,1'b0,1'b0,1'b1,1'b0, 3'd0,3'd0, 2'b00,1'b0, 3'd5, 9'o014}, // R6
        {4'd6, 1'b0,1'b0,1'b0,1'b1,1'b1, 3'd3,3'd5, 2'b00,1'b0, 3'd5, 9'o014}, // R6
        {4'd8, 1'b1,1'b0,1'b0,1'b0,1'b0, 3'd0,3'd0, 2'b00,1'b1, 3'd0, 9'o070}, // R8
        {4'd8, 1'b0,1'b0,1'b0,1'b1,1'b1, 3'd6,3'd0, 2'b00,1'b1, 3'd0, 9'o070}, // R8
        {4'd9, 1'b1,1'b0,1'b0,1'b0,1'b0, 3'd0,3'd0, 2'b11,1'b1, 3'd1, 9'o250}, // R9
        {4'd9, 1'b0,1'b0,1'b0,1'b1,1'b1, 3'd6,3'd2, 2'b01,1'b1, 3'd4, 9'o210}  // R9
    };

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        @(negedge clk);
        // R1
        chk("R1 valid", svc_valid, 0);
        chk("R1 stalled", stalled, 0);
        chk("R1 sel", svc_sel, 0);
        chk("R1 prefetch", prefetch_ok, 1);

        for (int i = 0; i < NV; i++) begin
            logic [29:0] e;
            logic exp_pf, kern_spl, irq_q;
            string tg;
            e = TBL[i];
            do_reset();
            @(negedge clk);
            pend_mmu = e[25]; pend_nxm = e[24]; pend_ysv = e[23];
            tbit_armed = e[22]; irq_req = e[21];
            irq_pri = e[20:18]; cpu_pri = e[17:15];
            cur_mode = e[14:13]; last_spl = e[12];
            irq_vec = (e[11:9] == 3'd4) ? e[8:0] : 9'o070;
            kern_spl = e[12] && (e[14:13] == 2'b00);
            irq_q = e[21] && (e[20:18] > e[17:15]);
            // R10: prefetch blocked by any pending event unless kernel SPL
            exp_pf = kern_spl || !(e[25] | e[24] | e[23] | e[22] | irq_q);
            #1;
            tg = $sformatf("R10 vec%0d prefetch", i);
            chk(tg, prefetch_ok, exp_pf);
            @(negedge clk);
            complete();
            tg = $sformatf("R%0d vec%0d valid", e[29:26], i);
            chk(tg, svc_valid, (e[11:9] != 3'd0));
            tg = $sformatf("R%0d vec%0d sel", e[29:26], i);
            chk(tg, svc_sel, e[11:9]);
            if (e[11:9] != 3'd0) begin
                tg = $sformatf("R%0d vec%0d vector", e[29:26], i);
                chk(tg, svc_vec, e[8:0]);
            end
        end

        // R11: single-cycle grant
        do_reset();
        @(negedge clk);
        pend_nxm = 1;
        complete();
        chk("R11 grant", svc_valid, 1);
        @(negedge clk);
        chk("R11 drop", svc_valid, 0);

        // R5: held-back trace is taken at RTI, not before
        do_reset();
        @(negedge clk);
        tbit_armed = 1; irq_req = 1; irq_pri = 3'd5; cpu_pri = 3'd0; irq_vec = 9'o300;
        complete();
        chk("R5 irq first", svc_sel, 4);
        @(negedge clk);
        complete();
        chk("R5 no trace in handler", svc_valid, 0);
        @(negedge clk);
        last_rti = 1;
        complete();
        chk("R5 trace after rti sel", svc_sel, 5);
        chk("R5 trace after rti vec", svc_vec, 9'o014);
        @(negedge clk);
        last_rti = 1;
        complete();
        chk("R5 trace once", svc_valid, 0);

        // R7: traced WAIT parks, interrupt wakes, trace at RTI
        do_reset();
        @(negedge clk);
        tbit_armed = 1; last_wait = 1;
        complete();
        chk("R7 stalled", stalled, 1);
        chk("R7 no grant", svc_valid, 0);
        repeat (3) @(negedge clk);
        chk("R7 still stalled", stalled, 1);
        irq_req = 1; irq_pri = 3'd2; cpu_pri = 3'd3;
        @(negedge clk);
        chk("R7 low irq ignored", stalled, 1);
        irq_pri = 3'd4; irq_vec = 9'o220;
        @(posedge clk);
        @(negedge clk);
        clear_in();
        chk("R7 wake sel", svc_sel, 4);
        chk("R7 wake vec", svc_vec, 9'o220);
        chk("R7 left stall", stalled, 0);
        @(negedge clk);
        last_rti = 1;
        complete();
        chk("R7 trace at rti", svc_sel, 5);

        // R7: untraced WAIT then RTI gives no trace
        do_reset();
        @(negedge clk);
        last_wait = 1;
        complete();
        chk("R7 untraced stall", stalled, 1);
        irq_req = 1; irq_pri = 3'd7; irq_vec = 9'o064;
        @(posedge clk);
        @(negedge clk);
        clear_in();
        chk("R7 untraced wake", svc_sel, 4);
        @(negedge clk);
        last_rti = 1;
        complete();
        chk("R7 no stray trace", svc_valid, 0);

        // R8: kernel SPL keeps prefetch on with a trap pending
        do_reset();
        @(negedge clk);
        pend_ysv = 1; last_spl = 1; cur_mode = 2'b00;
        #1;
        chk("R8 prefetch forced", prefetch_ok, 1);
        cur_mode = 2'b11;
        #1;
        chk("R9 prefetch user spl", prefetch_ok, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule